// File: doc/BRIEF.md
# Eight-Bit Universal Shift Register with Rotate

This block is an eight-bit storage register whose next contents are picked on every rising clock edge by a three-bit operation code. It can take a new word from its parallel input, shift by one place in either direction with a serial fill bit, rotate by one place in either direction, or fill itself with ones. A clear input, active high, empties the register at once without waiting for a clock edge, and it overrides every operation code.

Each bit is a flip-flop with asynchronous clear, fed by its own next-state selector. The selector chooses among the parallel data bit, the bit to its left, the bit to its right and a constant one. The two end bits take the serial input or the opposite end bit, depending on whether the code asks for a shift or a rotate. The output is the flip-flop state itself, with no logic after it.

Top module: `usr_rotate_reg`

## Requirements
- R1: While `clr` is 1, `q` is 8'h00 within the same clock period, without a clock edge, whatever the value of `mode`.
- R2: With `mode` 3'b000 or 3'b001 (bit 0 ignored), a rising edge copies `din` into `q`.
- R3: With `mode` 3'b010, a rising edge sets `q[i]` to the old `q[i+1]` for i in 0..6 and sets `q[7]` to `ser_r`.
- R4: With `mode` 3'b011, a rising edge sets `q[i]` to the old `q[i+1]` for i in 0..6 and sets `q[7]` to the old `q[0]`.
- R5: With `mode` 3'b100, a rising edge sets `q[i]` to the old `q[i-1]` for i in 1..7 and sets `q[0]` to `ser_l`.
- R6: With `mode` 3'b101, a rising edge sets `q[i]` to the old `q[i-1]` for i in 1..7 and sets `q[0]` to the old `q[7]`.
- R7: With `mode` 3'b110 or 3'b111 (bit 0 ignored), a rising edge sets `q` to 8'hFF.
- R8: When `clr` falls, `q` stays 8'h00 until the next rising edge, where the code on `mode` takes effect.
- R9: Without `clr`, `q` changes only at a rising edge; changes of `mode`, `din`, `ser_l` or `ser_r` between edges leave `q` unchanged.
- R10: `ser_l` and `ser_r` have no effect in load, rotate and set modes, and `ser_l` has no effect in right shift and `ser_r` none in left shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all operations act on its rising edge |
| clr | input | 1 | Asynchronous clear, active high |
| mode | input | 3 | Operation code (see R2 to R7) |
| din | input | 8 | Parallel data for load |
| ser_l | input | 1 | Fill bit entering `q[0]` on a left shift |
| ser_r | input | 1 | Fill bit entering `q[7]` on a right shift |
| q | output | 8 | Register contents |

## Verification
Every operation code gives its result one rising edge after the code is presented, so the bench drives inputs at the falling edge and compares `q` a quarter period after the following rising edge against its own model. The clear is checked one time unit after it rises, before any edge, and its release is checked both just before and just after the next rising edge. Stability between edges is checked by changing inputs half-way through a period and sampling again before the edge arrives.

// File: rtl/usr_pkg.sv
// Package: shared width and operation type for the universal shift register.
// Assumes the register is at least two bits wide.
package usr_pkg;

    localparam int USR_W = 8;

    typedef enum logic [2:0] {
        OP_LOAD = 3'd0,
        OP_SHR  = 3'd1,
        OP_ROR  = 3'd2,
        OP_SHL  = 3'd3,
        OP_ROL  = 3'd4,
        OP_SET  = 3'd5
    } usr_op_e;

endpackage

// File: rtl/usr_mode_dec.sv
// Module: usr_mode_dec
// Turns the three-bit operation code into an internal operation.
// Assumes the code is valid every cycle; codes 00x and 11x ignore bit 0.
module usr_mode_dec
    import usr_pkg::*;
(
    input  logic [2:0] mode,
    output usr_op_e    op
);

    // Map each code to its operation; bit 0 is a don't-care for load and set.
    always_comb begin
        unique casez (mode)
            3'b00?:  op = OP_LOAD;
            3'b010:  op = OP_SHR;
            3'b011:  op = OP_ROR;
            3'b100:  op = OP_SHL;
            3'b101:  op = OP_ROL;
            default: op = OP_SET;
        endcase
    end

endmodule

// File: rtl/usr_bit_cell.sv
// Module: usr_bit_cell
// One register bit: a next-state selector in front of a flip-flop with
// asynchronous active-high clear. Assumes the neighbour sources are already
// resolved by the caller (serial or rotate at the ends).
module usr_bit_cell
    import usr_pkg::*;
(
    input  logic    clk,
    input  logic    clr,
    input  usr_op_e op,
    input  logic    par_bit,
    input  logic    from_hi,
    input  logic    from_lo,
    output logic    q_bit
);

    logic d_nxt;

    // Choose the next value of this bit from the operation.
    always_comb begin
        unique case (op)
            OP_LOAD:        d_nxt = par_bit;
            OP_SHR, OP_ROR: d_nxt = from_hi;
            OP_SHL, OP_ROL: d_nxt = from_lo;
            default:        d_nxt = 1'b1;
        endcase
    end

    // Store the bit; clear acts without a clock edge.
    always_ff @(posedge clk or posedge clr) begin
        if (clr) q_bit <= 1'b0;
        else     q_bit <= d_nxt;
    end

endmodule

// File: rtl/usr_rotate_reg.sv
// Module: usr_rotate_reg
// Universal shift register with load, shift, rotate and set-to-ones modes,
// and an asynchronous active-high clear. Assumes clr is released away from
// the rising clock edge.
module usr_rotate_reg
    import usr_pkg::*;
#(
    parameter int W = USR_W
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [2:0]   mode,
    input  logic [W-1:0] din,
    input  logic         ser_l,
    input  logic         ser_r,
    output logic [W-1:0] q
);

    localparam int TOP = W - 1;

    usr_op_e     op;
    logic [W-1:0] hi_src;
    logic [W-1:0] lo_src;

    usr_mode_dec u_dec (
        .mode (mode),
        .op   (op)
    );

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            // Source from the higher neighbour: serial or wrap at the top end.
            if (i == TOP) begin : g_hi_end
                always_comb hi_src[i] = (op == OP_ROR) ? q[0] : ser_r;
            end else begin : g_hi_mid
                always_comb hi_src[i] = q[i+1];
            end
            // Source from the lower neighbour: serial or wrap at the bottom end.
            if (i == 0) begin : g_lo_end
                always_comb lo_src[i] = (op == OP_ROL) ? q[TOP] : ser_l;
            end else begin : g_lo_mid
                always_comb lo_src[i] = q[i-1];
            end

            usr_bit_cell u_cell (
                .clk     (clk),
                .clr     (clr),
                .op      (op),
                .par_bit (din[i]),
                .from_hi (hi_src[i]),
                .from_lo (lo_src[i]),
                .q_bit   (q[i])
            );
        end
    endgenerate

    // R1
    clr_empty_chk: assert property (@(posedge clk) clr |-> (q == '0));

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (clr)
        (mode[2:1] == 2'b00) |=> (q == $past(din)));

    // R3
    shr_fill_chk: assert property (@(posedge clk) disable iff (clr)
        (mode == 3'b010) |=> (q == {$past(ser_r), $past(q[TOP:1])}));

    // R4
    ror_wrap_chk: assert property (@(posedge clk) disable iff (clr)
        (mode == 3'b011) |=> (q == {$past(q[0]), $past(q[TOP:1])}));

    // R5
    shl_fill_chk: assert property (@(posedge clk) disable iff (clr)
        (mode == 3'b100) |=> (q == {$past(q[TOP-1:0]), $past(ser_l)}));

    // R6
    rol_wrap_chk: assert property (@(posedge clk) disable iff (clr)
        (mode == 3'b101) |=> (q == {$past(q[TOP-1:0]), $past(q[TOP])}));

    // R7
    set_ones_chk: assert property (@(posedge clk) disable iff (clr)
        (mode[2:1] == 2'b11) |=> (q == '1));

endmodule

// File: tb/test_usr_rotate_reg.sv
module test_usr_rotate_reg;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clr;
    logic [2:0]   mode;
    logic [W-1:0] din;
    logic         ser_l;
    logic         ser_r;
    logic [W-1:0] q;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] mdl;

    usr_rotate_reg #(.W(W)) i_usr_rotate_reg (
        .clk   (clk),
        .clr   (clr),
        .mode  (mode),
        .din   (din),
        .ser_l (ser_l),
        .ser_r (ser_r),
        .q     (q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] next_of(input logic [W-1:0] r, input logic [2:0] m,
                                             input logic [W-1:0] d, input logic sl, input logic sr);
        case (m)
            3'b000, 3'b001: return d;
            3'b010:         return {sr, r[W-1:1]};
            3'b011:         return {r[0], r[W-1:1]};
            3'b100:         return {r[W-2:0], sl};
            3'b101:         return {r[W-2:0], r[W-1]};
            default:        return '1;
        endcase
    endfunction

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s q=%h expected=%h", req, got, exp);
        end
    endtask

    // One clocked operation: drive at falling edge, compare after rising edge.
    task automatic step(input string req, input logic [2:0] m, input logic [W-1:0] d,
                        input logic sl, input logic sr);
        @(negedge clk);
        mode = m; din = d; ser_l = sl; ser_r = sr;
        mdl = next_of(mdl, m, d, sl, sr);
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk(req, q, mdl);
    endtask

    task automatic t_reset;
        clr = 1'b1; mode = 3'b110; din = '0; ser_l = 1'b0; ser_r = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 reset state", q, '0);
        @(negedge clk);
        clr = 1'b0;
        mdl = '0;
    endtask

    task automatic t_load;
        step("R2 load 000", 3'b000, 8'hA5, 1'b1, 1'b1);
        step("R2 load 001", 3'b001, 8'h3C, 1'b0, 1'b0);
        step("R10 load ignores serial", 3'b000, 8'h81, 1'b1, 1'b0);
    endtask

    task automatic t_shr;
        step("R2 load", 3'b000, 8'h96, 1'b0, 1'b0);
        step("R3 shift right fill 1", 3'b010, 8'h00, 1'b0, 1'b1);
        step("R3 shift right fill 0", 3'b010, 8'hFF, 1'b1, 1'b0);
        step("R10 shr ignores ser_l", 3'b010, 8'h00, 1'b1, 1'b1);
    endtask

    task automatic t_ror;
        step("R2 load", 3'b000, 8'h01, 1'b0, 1'b0);
        step("R4 rotate right wrap", 3'b011, 8'h00, 1'b0, 1'b0);
        step("R4 rotate right", 3'b011, 8'h00, 1'b1, 1'b1);
        step("R10 ror ignores serial", 3'b011, 8'hFF, 1'b0, 1'b1);
    endtask

    task automatic t_shl;
        step("R2 load", 3'b000, 8'h69, 1'b0, 1'b0);
        step("R5 shift left fill 1", 3'b100, 8'h00, 1'b1, 1'b0);
        step("R5 shift left fill 0", 3'b100, 8'hFF, 1'b0, 1'b1);
        step("R10 shl ignores ser_r", 3'b100, 8'h00, 1'b1, 1'b1);
    endtask

    task automatic t_rol;
        step("R2 load", 3'b000, 8'h80, 1'b0, 1'b0);
        step("R6 rotate left wrap", 3'b101, 8'h00, 1'b0, 1'b0);
        step("R6 rotate left", 3'b101, 8'h00, 1'b1, 1'b1);
        step("R10 rol ignores serial", 3'b101, 8'hFF, 1'b1, 1'b0);
    endtask

    task automatic t_set;
        step("R2 load", 3'b000, 8'h00, 1'b0, 1'b0);
        step("R7 set 110", 3'b110, 8'h00, 1'b0, 1'b0);
        step("R2 load", 3'b001, 8'h12, 1'b0, 1'b0);
        step("R7 set 111", 3'b111, 8'h00, 1'b1, 1'b1);
    endtask

    task automatic t_async_clear;
        step("R2 load", 3'b000, 8'hC3, 1'b0, 1'b0);
        @(negedge clk);
        mode = 3'b111;
        #1;
        clr = 1'b1;
        #1;
        chk("R1 clear without edge", q, '0);
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk("R1 clear overrides set", q, '0);
        @(negedge clk);
        clr = 1'b0;
        #1;
        chk("R8 release holds zero", q, '0);
        @(posedge clk);
        #(CLK_PERIOD/4);
        mdl = '1;
        chk("R8 mode applies at next edge", q, mdl);
    endtask

    task automatic t_stable;
        step("R2 load", 3'b000, 8'h5A, 1'b0, 1'b0);
        @(negedge clk);
        mode = 3'b000; din = 8'hFF; ser_l = 1'b1; ser_r = 1'b1;
        #1;
        chk("R9 stable after din change", q, mdl);
        mode = 3'b010;
        #1;
        chk("R9 stable after mode change", q, mdl);
        @(posedge clk);
        #(CLK_PERIOD/4);
        mdl = next_of(mdl, 3'b010, 8'hFF, 1'b1, 1'b1);
        chk("R3 shift after mid-cycle change", q, mdl);
    endtask

    task automatic t_sweep;
        for (int m = 0; m < 8; m++) begin
            step("R2 load", 3'b000, 8'hB4 ^ 8'(m), 1'b0, 1'b0);
            step("R2-R7 sweep", 3'(m), 8'h4D, m[0], ~m[0]);
        end
    endtask

    initial begin
        t_reset;
        t_load;
        t_shr;
        t_ror;
        t_shl;
        t_rol;
        t_set;
        t_async_clear;
        t_stable;
        t_sweep;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired q=%h expected=done", q);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule